// File: doc/BRIEF.md
# I2C Start/Stop Hold-Time Qualifier

This block sits in front of an I2C slave and watches the bus lines for the two framing conditions. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. It does not act on the bare SDA edge. It waits until the line state that follows the edge has held for a programmed number of sample periods, then raises a one-cycle `start_det` or `stop_det` pulse. A START pulse is what a downstream address matcher waits for.

Both bus lines pass through a multi-flop synchronizer. A sample enable, divided down from the system clock (every second clock by default), paces all edge evaluation and all counting. An 8-bit setup register selects the hold requirement:

- When its top bit is clear, a single sample is enough.
- When the top bit is set, the low seven bits plus one give the number of sample periods, from 1 to 128.

Each candidate edge latches its own limit. A rewrite of the register therefore affects only the candidates that follow it.

Top module: `i2c_hold_qualifier`

## Requirements
- R1: After reset the setup register holds 00h and both pulse outputs are low, so the block starts in single-sample mode.
- R2: With setup bit 7 clear, qualification uses exactly one sample period, whatever bits 6..0 hold.
- R3: With setup bit 7 set, qualification needs N = bits[6:0] + 1 consecutive sample periods (81h gives 2, 8Bh gives 12, FFh gives 128). Counting from the bus-pin edge driven between clock edges, the pulse is seen after 2N+1 or 2N+2 system clock edges, with the default divider and two synchronizer stages.
- R4: A START candidate is an SDA fall seen while SCL is high in both the previous and current sample. A STOP candidate is an SDA rise under the same SCL condition. SDA changes while SCL is low, and SCL rising while SDA is steady, produce no pulse.
- R5: SCL going low before the count completes abandons the qualification, and no pulse follows.
- R6: SDA returning to its pre-edge level before the count completes abandons the qualification. If SCL is still high, that return is itself a new candidate of the opposite kind, qualified from its own edge.
- R7: `start_det` and `stop_det` are each high for exactly one system clock and never high together.
- R8: A setup write that arrives during a qualification does not change that qualification. It applies from the next candidate edge.
- R9: Samples are taken once every SAMPLE_DIV system clocks, and a pulse is produced only at a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_wdata | input | 8 | Setup value: bit 7 enable, bits 6..0 count field |
| scl_in | input | 1 | Asynchronous SCL line |
| sda_in | input | 1 | Asynchronous SDA line |
| start_det | output | 1 | One-cycle pulse on a qualified START |
| stop_det | output | 1 | One-cycle pulse on a qualified STOP |

## Verification
The hardest case to reach from the ports is an aborted START whose SDA return is then itself qualified as a STOP. It needs a long hold setting, a SDA fall, and a SDA rise placed well inside the twelve-sample window while SCL stays high. The bench times that rise a few clocks after the fall. It checks that no START pulse ever appears, and that a STOP pulse arrives at exactly the twelve-sample latency counted from the rise. A second hard case is a setup rewrite during an active count. A forked thread writes 80h four clocks into a twelve-sample qualification, and the bench checks that the full latency is still observed.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam int CFG_W   = 8;
  localparam int FIELD_W = CFG_W - 1;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic [1:0] {
    Q_IDLE  = 2'd0,
    Q_START = 2'd1,
    Q_STOP  = 2'd2
  } qual_state_e;

  function automatic logic [CNT_W-1:0] hold_limit(input logic [CFG_W-1:0] cfg);
    logic [CNT_W-1:0] lim;
    if (cfg[CFG_W-1]) lim = {1'b0, cfg[FIELD_W-1:0]} + 1'b1;
    else              lim = CNT_W'(1);
    return lim;
  endfunction
endpackage

// File: rtl/hq_sync.sv
module hq_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hq_tick.sv
module hq_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_full
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R9
    end
  endgenerate
endmodule

// File: rtl/hq_cfg_reg.sv
module hq_cfg_reg
  import hq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CNT_W-1:0] limit
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

  assign limit = hold_limit(cfg_q);

  AST_CFG_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == '0)); // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(we) && !$past(rst)) |-> $stable(cfg_q)); // R8
endmodule

// File: rtl/hq_tracker.sv
module hq_tracker
  import hq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic [CNT_W-1:0] limit,
  output logic             start_det,
  output logic             stop_det
);
  qual_state_e      state;
  logic             scl_p, sda_p;
  logic [CNT_W-1:0] cnt, lim_q, cnt_nx;
  logic             cand_start, cand_stop, held;

  assign cand_start = scl_p & scl_s &  sda_p & ~sda_s;
  assign cand_stop  = scl_p & scl_s & ~sda_p &  sda_s;
  assign held       = scl_s & (sda_s == (state == Q_STOP));
  assign cnt_nx     = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= Q_IDLE;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
      cnt       <= '0;
      lim_q     <= CNT_W'(1);
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      if (tick) begin
        scl_p <= scl_s;
        sda_p <= sda_s;
        if (cand_start || cand_stop) begin
          lim_q <= limit;
          cnt   <= CNT_W'(1);
          if (limit == CNT_W'(1)) begin
            start_det <= cand_start;
            stop_det  <= cand_stop;
            state     <= Q_IDLE;
          end else begin
            state <= cand_start ? Q_START : Q_STOP;
          end
        end else if (state != Q_IDLE) begin
          if (!held) begin
            state <= Q_IDLE;
          end else if (cnt_nx == lim_q) begin
            start_det <= (state == Q_START);
            stop_det  <= (state == Q_STOP);
            state     <= Q_IDLE;
          end else begin
            cnt <= cnt_nx;
          end
        end
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det)); // R7
  AST_START_ONE: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !start_det); // R7
  AST_STOP_ONE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !stop_det); // R7
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |-> $past(tick)); // R9
  AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    start_det |-> ($past(scl_s) && !$past(sda_s))); // R4
  AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    stop_det |-> ($past(scl_s) && $past(sda_s))); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state != Q_IDLE) |-> (cnt < lim_q)); // R3
  AST_LIMIT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    ((state != Q_IDLE) && $past(state != Q_IDLE) &&
     !$past(tick && (cand_start || cand_stop))) |-> $stable(lim_q)); // R8
  AST_SCL_LOW_ABORT: assert property (@(posedge clk) disable iff (rst)
    (tick && !scl_s && (state != Q_IDLE)) |=> (state == Q_IDLE) && !start_det && !stop_det); // R5
endmodule

// File: rtl/i2c_hold_qualifier.sv
module i2c_hold_qualifier
  import hq_pkg::*;
#(
  parameter int SAMPLE_DIV  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             start_det,
  output logic             stop_det
);
  logic [1:0]       bus_s;
  logic             tick;
  logic [CNT_W-1:0] limit;

  hq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (bus_s)
  );

  hq_tick #(.DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  hq_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .limit (limit)
  );

  hq_tracker u_trk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .limit     (limit),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!start_det && !stop_det)); // R1
endmodule

// File: tb/i2c_hold_qualifier_tb.sv
module i2c_hold_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       start_det, stop_det;

  int checks = 0, errors = 0;
  int start_cnt = 0, stop_cnt = 0, width_err = 0, both_err = 0;
  logic prev_start = 1'b0, prev_stop = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_hold_qualifier u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .scl_in(scl_in), .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det)
  );

  always @(negedge clk) begin
    if (start_det) start_cnt++;
    if (stop_det)  stop_cnt++;
    if (start_det && prev_start) width_err++;
    if (stop_det && prev_stop)   width_err++;
    if (start_det && stop_det)   both_err++;
    prev_start = start_det;
    prev_stop  = stop_det;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_idle();
    @(negedge clk); scl_in = 1'b0;
    wait_cyc(4);    sda_in = 1'b1;
    wait_cyc(4);    scl_in = 1'b1;
    wait_cyc(10);
  endtask

  // Called right after an SDA edge driven at a negedge; checks R3 latency window.
  task automatic meas(input bit want_start, input int n, input string req);
    int k = 0;
    int other0 = want_start ? stop_cnt : start_cnt;
    int other1;
    for (int i = 1; i <= 2 * n + 12; i++) begin
      @(negedge clk);
      if ((want_start ? start_det : stop_det) === 1'b1) begin
        k = i;
        break;
      end
    end
    other1 = want_start ? stop_cnt : start_cnt;
    check(k == 2 * n + 1 || k == 2 * n + 2, req, k, 2 * n + 1);
    check(other1 == other0, {req, " other kind"}, other1 - other0, 0);
  endtask

  task automatic t_reset();
    check(start_det === 1'b0 && stop_det === 1'b0, "R1 outputs", {start_det, stop_det}, 0);
    bus_idle();
    @(negedge clk); sda_in = 1'b0;
    meas(1'b1, 1, "R1 default single sample");
  endtask

  task automatic t_disabled_field();
    bus_idle();
    set_cfg(8'h0B);
    @(negedge clk); sda_in = 1'b0;
    meas(1'b1, 1, "R2 start bit7 clear");
    wait_cyc(4);
    sda_in = 1'b1;
    meas(1'b0, 1, "R2 R4 stop bit7 clear");
  endtask

  task automatic t_count(input logic [7:0] v, input int n);
    bus_idle();
    set_cfg(v);
    @(negedge clk); sda_in = 1'b0;
    meas(1'b1, n, "R3 start count");
    wait_cyc(4);
    sda_in = 1'b1;
    meas(1'b0, n, "R3 R9 stop count");
  endtask

  task automatic t_scl_low_data();
    int s0, p0;
    bus_idle();
    set_cfg(8'h80);
    s0 = start_cnt; p0 = stop_cnt;
    scl_in = 1'b0; wait_cyc(6);
    sda_in = 1'b0; wait_cyc(6);
    sda_in = 1'b1; wait_cyc(6);
    sda_in = 1'b0; wait_cyc(6);
    scl_in = 1'b1; wait_cyc(20);
    check(start_cnt == s0 && stop_cnt == p0, "R4 no pulse while SCL low",
          start_cnt + stop_cnt - s0 - p0, 0);
  endtask

  task automatic t_abort_scl();
    int s0;
    bus_idle();
    set_cfg(8'h8B);
    s0 = start_cnt;
    @(negedge clk); sda_in = 1'b0;
    wait_cyc(10);
    scl_in = 1'b0;
    wait_cyc(40);
    check(start_cnt == s0, "R5 SCL low aborts start", start_cnt - s0, 0);
  endtask

  task automatic t_abort_sda();
    int s0;
    bus_idle();
    set_cfg(8'h8B);
    s0 = start_cnt;
    @(negedge clk); sda_in = 1'b0;
    wait_cyc(8);
    sda_in = 1'b1;
    meas(1'b0, 12, "R6 return edge qualifies as stop");
    wait_cyc(10);
    check(start_cnt == s0, "R6 aborted start silent", start_cnt - s0, 0);
  endtask

  task automatic t_cfg_midway();
    bus_idle();
    set_cfg(8'h8B);
    @(negedge clk); sda_in = 1'b0;
    fork
      meas(1'b1, 12, "R8 write mid-qualification ignored");
      begin wait_cyc(4); set_cfg(8'h80); end
    join
    wait_cyc(4);
    sda_in = 1'b1;
    meas(1'b0, 1, "R8 new value on next candidate");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_disabled_field();
    t_count(8'h80, 1);
    t_count(8'h81, 2);
    t_count(8'h8B, 12);
    t_count(8'hFF, 128);
    t_scl_low_data();
    t_abort_scl();
    t_abort_sda();
    t_cfg_midway();
    wait_cyc(10);
    check(width_err == 0, "R7 pulse width", width_err, 0);
    check(both_err == 0, "R7 exclusive pulses", both_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule